// File: doc/BRIEF.md
# Static Slot Frame Acceptance Checker

This block judges each frame received in a static slot of a time-triggered automotive bus. A bit decoder upstream hands it a header strobe with the decoded fields (identifier, payload length, preamble flag, null-frame flag, reserved bit, cycle count) and the payload. It also hands over a strobe for any syntax error it detects. The block compares the header with the slot it arrives in and with the configured static payload length. At the end of the slot it publishes a status word for that slot: valid frame, syntax error, content error and the null-frame flag.

A register of frame contents holds the header fields and the payload of the last accepted frame. Only a frame that is valid and carries data replaces these contents. A channel-wide aggregate collects the per-slot flags in sticky bits until the host clears them. CRC checking, bit decoding and the host register access are done elsewhere.

Top module: `static_slot_acceptor`

## Requirements
- R1: A header whose identifier is zero, or differs from `cur_slot_i`, gives content error 1 and valid frame 0 in that slot's status.
- R2: A header whose length field differs from `cfg_len_i` gives content error 1 and valid frame 0.
- R3: The null-frame flag is active low (0 = null frame, no data). Its received value appears on `st_null_n_o` for the slot, and it is 0 for a slot without a header.
- R4: A header with preamble flag 1 and null-frame flag 0 gives content error 1 and valid frame 0.
- R5: A header with preamble flag 1 and null-frame flag 1 (with a correct identifier and length) is a valid frame, and `fc_ppi_o` becomes 1.
- R6: The frame contents outputs (`fc_*`) change only for a valid frame whose null-frame flag is 1. Invalid frames and null frames leave them unchanged.
- R7: The reserved header bit takes no part in the checks. Its received value is stored unchanged in `fc_rsv_o`.
- R8: A `syn_err_i` pulse during a slot gives syntax error 1 and valid frame 0 for that slot.
- R9: Status outputs change only in the cycle after `slot_end_i`. The per-slot working flags clear at `slot_start_i`, so a slot without a header or error reports all flags 0. All outputs are 0 after reset.
- R10: `agg_valid_o`, `agg_syntax_o` and `agg_content_o` OR in the per-slot flags at each slot end. They hold at 1 until a `host_clr_i` pulse, which zeroes them one cycle later.
- R11: When `host_clr_i` and a slot end that sets a flag fall in the same cycle, the flag being set ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start_i | input | 1 | First cycle of a static slot |
| slot_end_i | input | 1 | Last cycle of a static slot; the status is latched here |
| cur_slot_i | input | ID_W | Number of the current slot |
| cfg_len_i | input | LEN_W | Configured static payload length |
| hdr_vld_i | input | 1 | Strobe for a decoded header and payload |
| hdr_id_i | input | ID_W | Frame identifier |
| hdr_len_i | input | LEN_W | Payload length field |
| hdr_ppi_i | input | 1 | Payload preamble flag |
| hdr_null_n_i | input | 1 | Null-frame flag, active low |
| hdr_rsv_i | input | 1 | Reserved header bit |
| hdr_cyc_i | input | CYC_W | Cycle count field |
| payload_i | input | PAY_W | Frame payload |
| syn_err_i | input | 1 | Decoder syntax-error strobe |
| host_clr_i | input | 1 | Host clear of the aggregate flags |
| st_valid_o | output | 1 | Slot status: valid frame |
| st_syntax_o | output | 1 | Slot status: syntax error |
| st_content_o | output | 1 | Slot status: content error |
| st_null_n_o | output | 1 | Slot status: received null-frame flag |
| fc_id_o | output | ID_W | Stored identifier |
| fc_len_o | output | LEN_W | Stored length |
| fc_ppi_o | output | 1 | Stored preamble flag |
| fc_null_n_o | output | 1 | Stored null-frame flag |
| fc_rsv_o | output | 1 | Stored reserved bit |
| fc_cyc_o | output | CYC_W | Stored cycle count |
| fc_payload_o | output | PAY_W | Stored payload |
| agg_valid_o | output | 1 | Sticky OR of valid frame |
| agg_syntax_o | output | 1 | Sticky OR of syntax error |
| agg_content_o | output | 1 | Sticky OR of content error |

## Verification
If a working flag is not cleared at slot start, the fault shows as an error or valid bit that carries into the next slot's status. That status appears one cycle after that slot's end, and an empty slot exposes it directly. A shadow copy that commits at the wrong time shows as `fc_*` values changing after a null or rejected frame, seen in the cycle after the slot end. A fault in the aggregate shows either as a bit that drops without a clear or as a bit lost when a set and a clear coincide, in both cases one cycle after the slot end.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  typedef struct packed {
    logic seen;
    logic syntax;
    logic content;
    logic null_n;
  } slot_flags_t;

  localparam int AGG_BITS = 3;
endpackage

// File: rtl/ssa_frame_check.sv
module ssa_frame_check #(
  parameter int ID_W  = 11,
  parameter int LEN_W = 7
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic [ID_W-1:0]  cur_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             ppi_i,
  input  logic             null_n_i,
  output logic             bad_o
);
  logic id_bad, len_bad, combo_bad;

  always_comb begin
    id_bad    = (id_i == '0) || (id_i != cur_i);
    len_bad   = (len_i != cfg_len_i);
    combo_bad = ppi_i && !null_n_i;
    bad_o     = id_bad || len_bad || combo_bad;
  end
endmodule

// File: rtl/ssa_slot_tracker.sv
module ssa_slot_tracker
  import ssa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        slot_start_i,
  input  logic        slot_end_i,
  input  logic        hdr_vld_i,
  input  logic        hdr_bad_i,
  input  logic        hdr_null_n_i,
  input  logic        syn_err_i,
  output logic        commit_o,
  output logic        st_valid_o,
  output slot_flags_t st_flags_o,
  output logic [AGG_BITS-1:0] set_o
);
  slot_flags_t work_q, work_d, base;
  logic        valid_d;

  always_comb begin
    base   = slot_start_i ? '0 : work_q;
    work_d = base;
    if (hdr_vld_i) begin
      work_d.seen    = 1'b1;
      work_d.content = base.content | hdr_bad_i;
      work_d.null_n  = hdr_null_n_i;
    end
    if (syn_err_i) work_d.syntax = 1'b1;
    valid_d  = work_d.seen && !work_d.content && !work_d.syntax;
    commit_o = slot_end_i && valid_d && work_d.null_n;
    set_o    = slot_end_i ? {valid_d, work_d.syntax, work_d.content} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q     <= '0;
      st_flags_o <= '0;
      st_valid_o <= 1'b0;
    end else begin
      work_q <= slot_end_i ? '0 : work_d;
      if (slot_end_i) begin
        st_flags_o <= work_d;
        st_valid_o <= valid_d;
      end
    end
  end

  // R8
  syntax_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    st_flags_o.syntax |-> !st_valid_o);

  // R1
  content_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    st_flags_o.content |-> !st_valid_o);

  // R9
  status_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_end_i) |-> ($stable(st_flags_o) && $stable(st_valid_o)));
endmodule

// File: rtl/ssa_contents_store.sv
module ssa_contents_store #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] data_i,
  input  logic         commit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] pick;

  always_comb pick = cap_i ? data_i : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      data_o   <= '0;
    end else begin
      if (cap_i)    shadow_q <= data_i;
      if (commit_i) data_o   <= pick;
    end
  end

  // R6
  contents_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_i) |-> $stable(data_o));
endmodule

// File: rtl/ssa_chan_agg.sv
module ssa_chan_agg
  import ssa_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [AGG_BITS-1:0] set_i,
  input  logic                clr_i,
  output logic [AGG_BITS-1:0] agg_o
);
  always_ff @(posedge clk) begin
    if (rst) agg_o <= '0;
    else     agg_o <= (clr_i ? '0 : agg_o) | set_i;
  end

  generate
    for (genvar g = 0; g < AGG_BITS; g++) begin : g_chk
      // R10
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(agg_o[g]) && !$past(clr_i)) |-> agg_o[g]);
      // R11
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(set_i[g]) |-> agg_o[g]);
    end
  endgenerate
endmodule

// File: rtl/static_slot_acceptor.sv
module static_slot_acceptor
  import ssa_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int LEN_W = 7,
  parameter int CYC_W = 6,
  parameter int PAY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_start_i,
  input  logic             slot_end_i,
  input  logic [ID_W-1:0]  cur_slot_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             hdr_vld_i,
  input  logic [ID_W-1:0]  hdr_id_i,
  input  logic [LEN_W-1:0] hdr_len_i,
  input  logic             hdr_ppi_i,
  input  logic             hdr_null_n_i,
  input  logic             hdr_rsv_i,
  input  logic [CYC_W-1:0] hdr_cyc_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             syn_err_i,
  input  logic             host_clr_i,
  output logic             st_valid_o,
  output logic             st_syntax_o,
  output logic             st_content_o,
  output logic             st_null_n_o,
  output logic [ID_W-1:0]  fc_id_o,
  output logic [LEN_W-1:0] fc_len_o,
  output logic             fc_ppi_o,
  output logic             fc_null_n_o,
  output logic             fc_rsv_o,
  output logic [CYC_W-1:0] fc_cyc_o,
  output logic [PAY_W-1:0] fc_payload_o,
  output logic             agg_valid_o,
  output logic             agg_syntax_o,
  output logic             agg_content_o
);
  localparam int HDR_W = 3 + CYC_W + LEN_W + ID_W;
  localparam int FC_W  = HDR_W + PAY_W;

  logic                hdr_bad;
  logic                commit;
  slot_flags_t         flags;
  logic [AGG_BITS-1:0] set_vec, agg_vec;
  logic [FC_W-1:0]     fc_in, fc_q;

  ssa_frame_check #(.ID_W(ID_W), .LEN_W(LEN_W)) chk_i (
    .id_i      (hdr_id_i),
    .cur_i     (cur_slot_i),
    .len_i     (hdr_len_i),
    .cfg_len_i (cfg_len_i),
    .ppi_i     (hdr_ppi_i),
    .null_n_i  (hdr_null_n_i),
    .bad_o     (hdr_bad)
  );

  ssa_slot_tracker trk_i (
    .clk          (clk),
    .rst          (rst),
    .slot_start_i (slot_start_i),
    .slot_end_i   (slot_end_i),
    .hdr_vld_i    (hdr_vld_i),
    .hdr_bad_i    (hdr_bad),
    .hdr_null_n_i (hdr_null_n_i),
    .syn_err_i    (syn_err_i),
    .commit_o     (commit),
    .st_valid_o   (st_valid_o),
    .st_flags_o   (flags),
    .set_o        (set_vec)
  );

  assign fc_in = {hdr_rsv_i, hdr_ppi_i, hdr_null_n_i, hdr_cyc_i,
                  hdr_len_i, hdr_id_i, payload_i};

  ssa_contents_store #(.W(FC_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .cap_i    (hdr_vld_i),
    .data_i   (fc_in),
    .commit_i (commit),
    .data_o   (fc_q)
  );

  ssa_chan_agg agg_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_vec),
    .clr_i (host_clr_i),
    .agg_o (agg_vec)
  );

  assign st_syntax_o  = flags.syntax;
  assign st_content_o = flags.content;
  assign st_null_n_o  = flags.null_n;
  assign {fc_rsv_o, fc_ppi_o, fc_null_n_o, fc_cyc_o,
          fc_len_o, fc_id_o, fc_payload_o} = fc_q;
  assign {agg_valid_o, agg_syntax_o, agg_content_o} = agg_vec;

  // R6
  null_never_stored_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fc_q) |-> (st_valid_o && st_null_n_o));

  // R10
  slot_flags_reach_agg_chk: assert property (@(posedge clk) disable iff (rst)
    (st_content_o && $past(slot_end_i)) |-> agg_content_o);
endmodule

// File: tb/static_slot_acceptor_tb.sv
module static_slot_acceptor_tb_top;
  localparam int ID_W = 11, LEN_W = 7, CYC_W = 6, PAY_W = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic slot_start_i = 0, slot_end_i = 0, hdr_vld_i = 0, syn_err_i = 0, host_clr_i = 0;
  logic [ID_W-1:0] cur_slot_i = '0, hdr_id_i = '0;
  logic [LEN_W-1:0] cfg_len_i = 7'd8, hdr_len_i = '0;
  logic hdr_ppi_i = 0, hdr_null_n_i = 0, hdr_rsv_i = 0;
  logic [CYC_W-1:0] hdr_cyc_i = '0;
  logic [PAY_W-1:0] payload_i = '0;
  logic st_valid_o, st_syntax_o, st_content_o, st_null_n_o;
  logic [ID_W-1:0] fc_id_o;
  logic [LEN_W-1:0] fc_len_o;
  logic fc_ppi_o, fc_null_n_o, fc_rsv_o;
  logic [CYC_W-1:0] fc_cyc_o;
  logic [PAY_W-1:0] fc_payload_o;
  logic agg_valid_o, agg_syntax_o, agg_content_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // expected stored contents and aggregate
  logic [ID_W-1:0] e_id = '0;
  logic [LEN_W-1:0] e_len = '0;
  logic e_ppi = 0, e_nn = 0, e_rsv = 0;
  logic [CYC_W-1:0] e_cyc = '0;
  logic [PAY_W-1:0] e_pay = '0;
  logic [2:0] e_agg = '0;

  always #4 clk = ~clk;

  static_slot_acceptor #(.ID_W(ID_W), .LEN_W(LEN_W), .CYC_W(CYC_W), .PAY_W(PAY_W)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_slot(input string req, input int cur, input bit hdr_en,
                          input int id, input int len, input bit ppi, input bit nn,
                          input bit rsv, input int cyc, input logic [63:0] pay,
                          input bit syn, input bit clr_end);
    bit content, valid;
    @(negedge clk); slot_start_i = 1; cur_slot_i = ID_W'(cur);
    @(negedge clk); slot_start_i = 0;
    if (hdr_en) begin
      hdr_vld_i = 1; hdr_id_i = ID_W'(id); hdr_len_i = LEN_W'(len);
      hdr_ppi_i = ppi; hdr_null_n_i = nn; hdr_rsv_i = rsv;
      hdr_cyc_i = CYC_W'(cyc); payload_i = pay;
    end
    @(negedge clk); hdr_vld_i = 0; syn_err_i = syn;
    @(negedge clk); syn_err_i = 0; slot_end_i = 1; host_clr_i = clr_end;
    @(negedge clk); slot_end_i = 0; host_clr_i = 0;
    content = hdr_en && (id == 0 || id != cur || len != 8 || (ppi && !nn));
    valid = hdr_en && !content && !syn;
    if (valid && nn) begin
      e_id = ID_W'(id); e_len = LEN_W'(len); e_ppi = ppi; e_nn = nn;
      e_rsv = rsv; e_cyc = CYC_W'(cyc); e_pay = pay;
    end
    e_agg = (clr_end ? 3'b000 : e_agg) | {valid, syn, content};
    chk({req, " valid"}, st_valid_o, valid);
    chk({req, " syntax"}, st_syntax_o, syn);
    chk({req, " content"}, st_content_o, content);
    chk({req, " null_n"}, st_null_n_o, hdr_en ? nn : 1'b0);
    chk({req, " fc_hdr"}, {fc_rsv_o, fc_ppi_o, fc_null_n_o, fc_cyc_o, fc_len_o, fc_id_o},
        {e_rsv, e_ppi, e_nn, e_cyc, e_len, e_id});
    chk({req, " fc_payload"}, fc_payload_o, e_pay);
    chk({req, " agg"}, {agg_valid_o, agg_syntax_o, agg_content_o}, e_agg);
  endtask

  task automatic t_reset;
    chk("R9 reset status", {st_valid_o, st_syntax_o, st_content_o, st_null_n_o}, 0);
    chk("R9 reset contents", fc_payload_o | 64'(fc_id_o), 0);
    chk("R9 reset agg", {agg_valid_o, agg_syntax_o, agg_content_o}, 0);
  endtask

  task automatic t_host_clear;
    @(negedge clk); host_clr_i = 1;
    @(negedge clk); host_clr_i = 0;
    e_agg = 3'b000;
    chk("R10 clear", {agg_valid_o, agg_syntax_o, agg_content_o}, 0);
  endtask

  task automatic t_status_held;
    repeat (3) @(negedge clk);
    chk("R9 status held between slots", {st_valid_o, st_content_o}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    run_slot("R7 R5 good frame",    5, 1, 5, 8, 0, 1, 1, 3, 64'h1122334455667788, 0, 0);
    run_slot("R1 id zero",          5, 1, 0, 8, 0, 1, 0, 4, 64'hDEAD, 0, 0);
    run_slot("R1 id mismatch",      5, 1, 6, 8, 0, 1, 0, 4, 64'hBEEF, 0, 0);
    run_slot("R2 length mismatch",  7, 1, 7, 9, 0, 1, 0, 4, 64'hCAFE, 0, 0);
    t_status_held();
    run_slot("R3 R6 null frame",    7, 1, 7, 8, 0, 0, 0, 9, 64'hF00D, 0, 0);
    run_slot("R4 preamble on null", 9, 1, 9, 8, 1, 0, 0, 9, 64'hABCD, 0, 0);
    run_slot("R5 preamble data",    9, 1, 9, 8, 1, 1, 0, 12, 64'h0102030405060708, 0, 0);
    run_slot("R8 syntax error",     3, 1, 3, 8, 0, 1, 1, 1, 64'h5555, 1, 0);
    run_slot("R9 empty slot",       4, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0, 0);
    t_host_clear();
    run_slot("R10 after clear",     4, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0, 0);
    run_slot("R11 set vs clear",    2, 1, 3, 8, 0, 1, 0, 1, 64'h77, 0, 1);
    run_slot("R6 R7 rsv zero",      2, 1, 2, 8, 0, 1, 0, 2, 64'h99, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule